// File: doc/BRIEF.md
# Floating-Point Condition Compare Unit

This block compares two IEEE-754 operands and turns the outcome into a condition-code update. It accepts three operand formats: one 32-bit single, one 64-bit double, or a pair of singles packed into 64 bits. A 4-bit predicate selects which outcomes make the result true: less, equal and unordered are ORed under mask bits, and a fourth bit makes any NaN raise an invalid-operation status. An absolute-value option compares the magnitudes of the two operands and ignores their signs.

The comparison itself is combinational. One register stage then drives a condition-code write of one bit, or two bits in paired mode, together with a status report for the control/status logic. If invalid is raised while the invalid trap is enabled, the status is reported but the condition-code write is suppressed. This matches the rule that the status update happens first and an enabled exception blocks the write.

Top module: `fcc_compare_unit`

## Requirements
- R1: The result bit is (cond[2] and less) or (cond[1] and equal) or (cond[0] and unordered).
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), the pair is unordered and neither less nor equal is true.
- R3: Invalid is raised when the pair is unordered and cond[3] is 1, or when either operand is a signalling NaN. A signalling NaN is a NaN whose fraction MSB is 1, and a NaN with fraction MSB 0 is quiet.
- R4: When in_abs is 1, the sign bits of both operands are ignored and magnitudes are compared.
- R5: +0 and -0 compare equal.
- R6: Ordered operands follow numeric order. A negative value is less than a positive one, and among negatives the larger magnitude is less.
- R7: Format single (in_fmt=00) compares bits [31:0] only. It writes only condition bit in_cc, so cc_mask is one-hot at in_cc and cc_data holds the result at that bit.
- R8: Format double (in_fmt=01) compares all 64 bits and writes condition bit in_cc.
- R9: Format paired (in_fmt=10) compares the halves independently. The lower halves write bit in_cc and the upper halves write bit (in_cc+1) mod NCC. The invalid status is the OR of the two halves.
- R10: When invalid is raised and in_trap_en is 1, stat_trap is 1 and no condition-code write occurs (cc_we, cc_mask and cc_data are all 0).
- R11: Outputs appear one clock after the accepted input. A cycle with in_valid low produces cc_we=0, stat_vld=0 and zero masks in the following cycle.
- R12: Under reset, every output is 0.
- R13: The reserved format (in_fmt=11) is ignored: no write and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compare request |
| in_fmt | input | 2 | 00 single, 01 double, 10 paired, 11 reserved |
| in_cond | input | 4 | Predicate: [3] signal on NaN, [2] less, [1] equal, [0] unordered |
| in_abs | input | 1 | Compare magnitudes |
| in_cc | input | CCW (3) | Target condition-code index |
| in_trap_en | input | 1 | Invalid-operation trap enable |
| in_opa | input | DBL_W (64) | Operand A |
| in_opb | input | DBL_W (64) | Operand B |
| cc_we | output | 1 | Condition-code write strobe |
| cc_mask | output | NCC (8) | Condition bits being written |
| cc_data | output | NCC (8) | New values of the written bits |
| stat_vld | output | 1 | Status report valid |
| stat_inv | output | 1 | Invalid-operation status |
| stat_trap | output | 1 | Enabled invalid exception; write suppressed |

## Verification
The bench builds the block with its default parameters: eight condition bits, and the standard 8/23 single and 11/52 double field splits. With eight condition bits, a paired compare at index 7 reaches the wrap onto bit 0. The standard field splits allow known encodings to be used directly (ones, twos, infinities, signed zeros, quiet and signalling NaNs), both packed into halves and as full doubles. The random stimulus is biased toward these special encodings and toward identical operands, so that equality, zero-sign and NaN-invalid paths occur often under every predicate.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

   typedef enum logic [1:0] {
      FMT_SGL  = 2'b00,
      FMT_DBL  = 2'b01,
      FMT_PAIR = 2'b10,
      FMT_RSVD = 2'b11
   } fcc_fmt_e;

   typedef struct packed {
      logic nan;
      logic snan;
      logic zero;
      logic neg;
   } fcc_class_t;

endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
   import fcc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] op,
   input  logic         abs_en,
   output fcc_class_t   cls,
   output logic [W-2:0] mag
);

   logic exp_ones;
   logic frac_nz;

   always_comb begin
      mag      = op[W-2:0];
      exp_ones = &op[W-2 -: EXP_W];
      frac_nz  = |op[FRAC_W-1:0];
      cls.nan  = exp_ones & frac_nz;
      cls.snan = exp_ones & frac_nz & op[FRAC_W-1];
      cls.zero = ~|op[W-2:0];
      cls.neg  = op[W-1] & ~abs_en;
   end

endmodule

// File: rtl/fcc_order.sv
module fcc_order
   import fcc_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  fcc_class_t       cls_a,
   input  fcc_class_t       cls_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             eq,
   output logic             lt
);

   logic mag_eq;
   logic mag_lt;
   logic lt_raw;

   always_comb begin
      mag_eq = (mag_a == mag_b);
      mag_lt = (mag_a < mag_b);
      eq     = (cls_a.zero & cls_b.zero) | ((cls_a.neg == cls_b.neg) & mag_eq);
      if (cls_a.neg != cls_b.neg)
         lt_raw = cls_a.neg;
      else if (cls_a.neg)
         lt_raw = ~mag_lt & ~mag_eq;
      else
         lt_raw = mag_lt;
      lt = lt_raw & ~eq;
   end

endmodule

// File: rtl/fcc_lane.sv
module fcc_lane
   import fcc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         abs_en,
   input  logic [3:0]   cond,
   output logic         hit,
   output logic         inv
);

   fcc_class_t   cls_a;
   fcc_class_t   cls_b;
   logic [W-2:0] mag_a;
   logic [W-2:0] mag_b;
   logic         ord_eq;
   logic         ord_lt;
   logic         unord;
   logic         less;
   logic         equal;

   fcc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
      .op(op_a), .abs_en(abs_en), .cls(cls_a), .mag(mag_a));

   fcc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
      .op(op_b), .abs_en(abs_en), .cls(cls_b), .mag(mag_b));

   fcc_order #(.MAG_W(W-1)) u_order (
      .cls_a(cls_a), .cls_b(cls_b), .mag_a(mag_a), .mag_b(mag_b),
      .eq(ord_eq), .lt(ord_lt));

   always_comb begin
      unord = cls_a.nan | cls_b.nan;
      less  = ord_lt & ~unord;
      equal = ord_eq & ~unord;
      hit   = (cond[2] & less) | (cond[1] & equal) | (cond[0] & unord);
      inv   = (unord & cond[3]) | cls_a.snan | cls_b.snan;
   end

   // R5: two zeros of any sign must be reported equal by the orderer
   always_comb begin
      a_r5_zero_equal : assert (!(cls_a.zero && cls_b.zero) || ord_eq);
   end

   // R6: ordering can never claim both less and equal
   always_comb begin
      a_r6_lt_eq_exclusive : assert (!(ord_eq && ord_lt));
   end

   // R3: a signalling operand is always a NaN operand
   always_comb begin
      a_r3_snan_is_nan : assert ((!cls_a.snan || cls_a.nan) && (!cls_b.snan || cls_b.nan));
   end

endmodule

// File: rtl/fcc_compare_unit.sv
module fcc_compare_unit
   import fcc_pkg::*;
#(
   parameter int NCC      = 8,
   parameter int SGL_EXP  = 8,
   parameter int SGL_FRAC = 23,
   parameter int DBL_EXP  = 11,
   parameter int DBL_FRAC = 52,
   localparam int SGL_W   = 1 + SGL_EXP + SGL_FRAC,
   localparam int DBL_W   = 1 + DBL_EXP + DBL_FRAC,
   localparam int CCW     = (NCC > 1) ? $clog2(NCC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_fmt,
   input  logic [3:0]       in_cond,
   input  logic             in_abs,
   input  logic [CCW-1:0]   in_cc,
   input  logic             in_trap_en,
   input  logic [DBL_W-1:0] in_opa,
   input  logic [DBL_W-1:0] in_opb,
   output logic             cc_we,
   output logic [NCC-1:0]   cc_mask,
   output logic [NCC-1:0]   cc_data,
   output logic             stat_vld,
   output logic             stat_inv,
   output logic             stat_trap
);

   localparam int NHALF = DBL_W / SGL_W;

   // elaboration-time parameter checks
   if (NCC < 2) begin : g_chk_ncc
      $error("fcc_compare_unit: NCC must be at least 2");
   end
   if ((NCC & (NCC - 1)) != 0) begin : g_chk_pow2
      $error("fcc_compare_unit: NCC must be a power of two");
   end
   if (2 * SGL_W != DBL_W) begin : g_chk_pack
      $error("fcc_compare_unit: two singles must fill one double");
   end

   logic [NHALF-1:0] hit_half;
   logic [NHALF-1:0] inv_half;
   logic             hit_dbl;
   logic             inv_dbl;

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      fcc_lane #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC)) u_lane (
         .op_a  (in_opa[h*SGL_W +: SGL_W]),
         .op_b  (in_opb[h*SGL_W +: SGL_W]),
         .abs_en(in_abs),
         .cond  (in_cond),
         .hit   (hit_half[h]),
         .inv   (inv_half[h]));
   end

   fcc_lane #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC)) u_dbl (
      .op_a  (in_opa),
      .op_b  (in_opb),
      .abs_en(in_abs),
      .cond  (in_cond),
      .hit   (hit_dbl),
      .inv   (inv_dbl));

   fcc_fmt_e       fmt;
   logic [CCW-1:0] idx_hi;
   logic [NCC-1:0] sel_lo;
   logic [NCC-1:0] sel_hi;
   logic [NCC-1:0] mask_n;
   logic [NCC-1:0] data_n;
   logic           inv_n;
   logic           known_n;
   logic           vld_n;
   logic           trap_n;
   logic           we_n;

   always_comb begin
      fmt     = fcc_fmt_e'(in_fmt);
      idx_hi  = in_cc + CCW'(1);
      sel_lo  = NCC'(1) << in_cc;
      sel_hi  = NCC'(1) << idx_hi;
      mask_n  = '0;
      data_n  = '0;
      inv_n   = 1'b0;
      known_n = 1'b1;
      case (fmt)
         FMT_SGL: begin
            mask_n = sel_lo;
            data_n = hit_half[0] ? sel_lo : '0;
            inv_n  = inv_half[0];
         end
         FMT_DBL: begin
            mask_n = sel_lo;
            data_n = hit_dbl ? sel_lo : '0;
            inv_n  = inv_dbl;
         end
         FMT_PAIR: begin
            mask_n = sel_lo | sel_hi;
            data_n = (hit_half[0] ? sel_lo : '0) | (hit_half[1] ? sel_hi : '0);
            inv_n  = |inv_half;
         end
         default: known_n = 1'b0;
      endcase
      vld_n  = in_valid & known_n;
      trap_n = vld_n & inv_n & in_trap_en;
      we_n   = vld_n & ~trap_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cc_we     <= 1'b0;
         cc_mask   <= '0;
         cc_data   <= '0;
         stat_vld  <= 1'b0;
         stat_inv  <= 1'b0;
         stat_trap <= 1'b0;
      end else begin
         cc_we     <= we_n;
         cc_mask   <= we_n ? mask_n : '0;
         cc_data   <= we_n ? data_n : '0;
         stat_vld  <= vld_n;
         stat_inv  <= vld_n & inv_n;
         stat_trap <= trap_n;
      end
   end

   // R10: an enabled exception never coexists with a write
   a_r10_trap_blocks_write : assert property (@(posedge clk) disable iff (!rst_n)
      stat_trap |-> (!cc_we && cc_mask == '0));

   // R3: a trap always carries the invalid status
   a_r3_trap_has_invalid : assert property (@(posedge clk) disable iff (!rst_n)
      stat_trap |-> (stat_inv && stat_vld));

   // R11: an idle cycle produces neither write nor status
   a_r11_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!cc_we && !stat_vld));

   // R7: written data stays inside the written bits
   a_r7_data_in_mask : assert property (@(posedge clk) disable iff (!rst_n)
      (cc_data & ~cc_mask) == '0);

   // R9: a paired request writes exactly two bits unless it traps
   a_r9_pair_two_bits : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b10) |=> (stat_vld && (stat_trap || $countones(cc_mask) == 2)));

   // R13: the reserved format is ignored
   a_r13_reserved_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b11) |=> (!cc_we && !stat_vld));

endmodule

// File: tb/test_fcc_compare_unit.sv
`timescale 1ns/1ps
module test_fcc_compare_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_fmt = 2'b00;
   logic [3:0]  in_cond = 4'h0;
   logic        in_abs = 1'b0;
   logic [2:0]  in_cc = 3'd0;
   logic        in_trap_en = 1'b0;
   logic [63:0] in_opa = '0;
   logic [63:0] in_opb = '0;
   logic        cc_we;
   logic [7:0]  cc_mask;
   logic [7:0]  cc_data;
   logic        stat_vld;
   logic        stat_inv;
   logic        stat_trap;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   fcc_compare_unit i_fcc_compare_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
      .in_cond(in_cond), .in_abs(in_abs), .in_cc(in_cc), .in_trap_en(in_trap_en),
      .in_opa(in_opa), .in_opb(in_opb), .cc_we(cc_we), .cc_mask(cc_mask),
      .cc_data(cc_data), .stat_vld(stat_vld), .stat_inv(stat_inv), .stat_trap(stat_trap));

   // ordering key: monotone in numeric value, zeros folded together
   function automatic logic [64:0] key_of(input logic [63:0] x, input int w);
      logic sgn;
      logic [63:0] m;
      sgn = (w == 32) ? x[31] : x[63];
      m   = (w == 32) ? {33'd0, x[30:0]} : {1'b0, x[62:0]};
      if (m == 0)       return {1'b1, 64'd0};
      else if (sgn)     return {1'b0, ~m};
      else              return {1'b1, m};
   endfunction

   // returns {inv, hit}
   function automatic logic [1:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input int w, input logic [3:0] c, input logic ab);
      logic na, nb, sa, sb, un, inv, hit;
      logic [64:0] ka, kb;
      if (w == 32) begin
         if (ab) begin a[31] = 1'b0; b[31] = 1'b0; end
         na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
         nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
         sa = na && a[22];
         sb = nb && b[22];
      end else begin
         if (ab) begin a[63] = 1'b0; b[63] = 1'b0; end
         na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
         nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
         sa = na && a[51];
         sb = nb && b[51];
      end
      un  = na || nb;
      inv = (un && c[3]) || sa || sb;
      if (un) hit = c[0];
      else begin
         ka  = key_of(a, w);
         kb  = key_of(b, w);
         hit = (c[2] && (ka < kb)) || (c[1] && (ka == kb));
      end
      return {inv, hit};
   endfunction

   task automatic apply(input string tag, input logic v, input logic [1:0] f,
                        input logic [3:0] c, input logic ab, input logic [2:0] cc,
                        input logic te, input logic [63:0] a, input logic [63:0] b);
      logic [1:0] r0, r1;
      logic [7:0] m0, m1, e_mask, e_data;
      logic e_vld, e_inv, e_trap, e_we;
      logic [20:0] act, exp_v;
      in_valid = v; in_fmt = f; in_cond = c; in_abs = ab; in_cc = cc;
      in_trap_en = te; in_opa = a; in_opb = b;
      m0 = 8'd1 << cc;
      m1 = 8'd1 << ((cc + 3'd1) & 3'd7);
      e_mask = 0; e_data = 0; e_inv = 0; e_vld = v && (f != 2'b11);
      case (f)
         2'b00: begin r0 = model(a, b, 32, c, ab); e_mask = m0;
                      e_data = r0[0] ? m0 : 8'd0; e_inv = r0[1]; end
         2'b01: begin r0 = model(a, b, 64, c, ab); e_mask = m0;
                      e_data = r0[0] ? m0 : 8'd0; e_inv = r0[1]; end
         2'b10: begin r0 = model(a, b, 32, c, ab);
                      r1 = model(a >> 32, b >> 32, 32, c, ab);
                      e_mask = m0 | m1;
                      e_data = (r0[0] ? m0 : 8'd0) | (r1[0] ? m1 : 8'd0);
                      e_inv = r0[1] | r1[1]; end
         default: ;
      endcase
      e_inv  = e_inv && e_vld;
      e_trap = e_inv && te;
      e_we   = e_vld && !e_trap;
      if (!e_we) begin e_mask = 0; e_data = 0; end
      exp_v = {e_we, e_mask, e_data, e_vld, e_inv, e_trap};
      @(negedge clk);
      act = {cc_we, cc_mask, cc_data, stat_vld, stat_inv, stat_trap};
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s act=%h exp=%h (we,mask,data,vld,inv,trap)", tag, act, exp_v);
      end
   endtask

   function automatic logic [31:0] pick_s();
      case ($urandom % 10)
         0: return 32'h0000_0000;
         1: return 32'h8000_0000;
         2: return 32'h7F80_0000;
         3: return 32'hFF80_0000;
         4: return {1'($urandom), 8'hFF, 1'b0, 22'($urandom) | 22'd1};
         5: return {1'($urandom), 8'hFF, 1'b1, 22'($urandom)};
         6: return 32'h3F80_0000;
         7: return 32'hBF80_0000;
         default: return $urandom;
      endcase
   endfunction

   function automatic logic [63:0] pick_d();
      case ($urandom % 10)
         0: return 64'h0;
         1: return 64'h8000_0000_0000_0000;
         2: return 64'h7FF0_0000_0000_0000;
         3: return {1'($urandom), 11'h7FF, 1'b0, 51'({$urandom, $urandom}) | 51'd1};
         4: return {1'($urandom), 11'h7FF, 1'b1, 51'({$urandom, $urandom})};
         5: return 64'h3FF0_0000_0000_0000;
         6: return 64'hBFF0_0000_0000_0000;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C0C));
      repeat (3) @(negedge clk);
      // R12: reset state
      checks++;
      if ({cc_we, cc_mask, cc_data, stat_vld, stat_inv, stat_trap} !== 21'd0) begin
         errors++;
         $display("FAIL R12 act=%h exp=0", {cc_we, cc_mask, cc_data, stat_vld, stat_inv, stat_trap});
      end
      rst_n = 1'b1;

      // R1: predicate terms
      apply("R1", 1, 2'b00, 4'b0100, 0, 3'd0, 0, 64'h3F80_0000, 64'h4000_0000);
      apply("R1", 1, 2'b00, 4'b0010, 0, 3'd0, 0, 64'h3F80_0000, 64'h4000_0000);
      apply("R1", 1, 2'b00, 4'b0010, 0, 3'd1, 0, 64'h4000_0000, 64'h4000_0000);
      apply("R1", 1, 2'b00, 4'b0110, 0, 3'd2, 0, 64'h4000_0000, 64'h3F80_0000);
      // R2: NaN is unordered
      apply("R2", 1, 2'b00, 4'b0110, 0, 3'd0, 0, 64'h7FBF_FFFF, 64'h3F80_0000);
      apply("R2", 1, 2'b00, 4'b0001, 0, 3'd0, 0, 64'h3F80_0000, 64'h7FBF_FFFF);
      // R3: invalid rules
      apply("R3", 1, 2'b00, 4'b1001, 0, 3'd3, 0, 64'h7FBF_FFFF, 64'h3F80_0000);
      apply("R3", 1, 2'b00, 4'b0001, 0, 3'd3, 0, 64'h7FC0_0000, 64'h3F80_0000);
      // R4: magnitude compare
      apply("R4", 1, 2'b00, 4'b0100, 0, 3'd4, 0, 64'hC040_0000, 64'h4000_0000);
      apply("R4", 1, 2'b00, 4'b0100, 1, 3'd4, 0, 64'hC040_0000, 64'h4000_0000);
      // R5: signed zeros
      apply("R5", 1, 2'b00, 4'b0010, 0, 3'd5, 0, 64'h0000_0000, 64'h8000_0000);
      apply("R5", 1, 2'b01, 4'b0100, 0, 3'd5, 0, 64'h8000_0000_0000_0000, 64'h0);
      // R6: negative ordering
      apply("R6", 1, 2'b00, 4'b0100, 0, 3'd6, 0, 64'hC000_0000, 64'hBF80_0000);
      apply("R6", 1, 2'b00, 4'b0100, 0, 3'd6, 0, 64'hBF80_0000, 64'h3F80_0000);
      // R7: upper bits ignored in single
      apply("R7", 1, 2'b00, 4'b0010, 0, 3'd5, 0, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000);
      // R8: double compare
      apply("R8", 1, 2'b01, 4'b0100, 0, 3'd2, 0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000);
      apply("R8", 1, 2'b01, 4'b1001, 0, 3'd2, 0, 64'h7FF7_FFFF_FFFF_FFFF, 64'h0);
      // R9: paired with wrap of the upper index
      apply("R9", 1, 2'b10, 4'b0100, 0, 3'd7, 0, 64'h4000_0000_3F80_0000, 64'h3F80_0000_4000_0000);
      apply("R9", 1, 2'b10, 4'b0011, 0, 3'd2, 0, 64'h7FC0_0000_3F80_0000, 64'h3F80_0000_3F80_0000);
      // R10: enabled trap blocks the write
      apply("R10", 1, 2'b00, 4'b0001, 0, 3'd1, 1, 64'h7FC0_0000, 64'h0);
      apply("R10", 1, 2'b00, 4'b0010, 0, 3'd1, 1, 64'h3F80_0000, 64'h3F80_0000);
      // R11: idle cycle
      apply("R11", 0, 2'b00, 4'b0010, 0, 3'd1, 0, 64'h3F80_0000, 64'h3F80_0000);
      // R13: reserved format
      apply("R13", 1, 2'b11, 4'b1111, 0, 3'd1, 1, 64'h7FC0_0000, 64'h0);

      for (int i = 0; i < 4000; i++) begin
         logic [1:0]  f;
         logic [63:0] a, b;
         string       tg;
         f = ($urandom % 16 == 0) ? 2'b11 : 2'($urandom % 3);
         if (f == 2'b01) begin a = pick_d(); b = pick_d(); end
         else begin a = {pick_s(), pick_s()}; b = {pick_s(), pick_s()}; end
         if ($urandom % 4 == 0) b = a;
         case (f)
            2'b00: tg = "R7 R1";
            2'b01: tg = "R8 R1";
            2'b10: tg = "R9 R1";
            default: tg = "R13";
         endcase
         apply(tg, ($urandom % 8) != 0, f, 4'($urandom), 1'($urandom),
               3'($urandom), ($urandom % 4) == 0, a, b);
      end

      in_valid = 1'b0;
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule